// File: doc/BRIEF.md
# Ethernet MAC Event Register and Transmit Stop Sequencer

This block collects the events of a simple Ethernet MAC in one 16-bit event register. Software reads the register over a small register bus and clears bits by writing ones to them. A second register holds an enable mask. A single interrupt line is raised whenever an enabled event is pending. The transmit path, the receive path and the DMA engine each report through single-cycle pulse inputs. A heartbeat watchdog watches the collision-test window after each transmitted frame.

The block also holds the transmit stop sequencer. It tracks how many frames sit in the transmit FIFO: complete frames are counted, and one partially loaded frame is flagged. While a stop is requested, the sequencer keeps the start-permit line low. It lets every frame that was already started drain, and then flags completion. A DMA bus error forces the same stop. In that case a partially loaded frame is dropped at once through an abort strobe, so the MAC ends it as an underrun with a corrupted CRC. Only complete frames are waited for.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready back-pressure. Every event input is a one-cycle strobe, sampled on the rising clock edge.

Top module: `eth_event_ctrl`

## Requirements
- R1: After reset the event register reads 0x0000, the mask register reads 0x07BF (every used bit enabled except bit 6), `irq` is 0 and `tx_allow` is 1.
- R2: A write with `reg_sel`=0 clears each event bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. The bit map is: 10 heartbeat missing, 9 receive frame too long, 8 transmit frame too long, 7 stop complete, 6 backoff expired, 5 bus error, 4 transmit frame done, 3 receive frame done, 2 receive busy, 1 transmit buffer, 0 receive buffer.
- R3: Bits 15 to 11 of both registers always read 0, even after a write of 0xFFFF. The mask register (`reg_sel`=1) stores bits 10 to 0 of the write data.
- R4: When a set strobe and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R5: Each event strobe sets its bit of R2 on the edge that samples it. `tx_bd_done` sets bit 4 and `rx_bd_done` sets bit 3.
- R6: While `stop_req` is high, `tx_allow` is 0 in the same cycle. With an empty FIFO, bit 7 is set on the first edge that samples `stop_req`.
- R7: During a stop, bit 7 is set only on the edge that samples the `tx_bd_done` which empties the FIFO. Every frame that was started counts, including a partial frame that is completed later.
- R8: `bus_err` sets bit 5. In the same cycle, `tx_abort` is high if a partial frame is loaded. Bit 7 is set on the same edge if no complete frame remains; otherwise it is set on the edge of the last complete frame's `tx_bd_done`.
- R9: After a stop, `tx_allow` returns to 1 only one edge after both `stop_req` is low and bit 7 reads 0.
- R10: With `hb_check_en`=1, a `tx_bd_done` opens a window of HB_WINDOW edges. If `hb_seen` is not sampled in that window, bit 10 is set one edge after the window ends. An `hb_seen` on the last window edge suppresses bit 10, and with `hb_check_en`=0 bit 10 is never set.
- R11: `irq` is the OR of all event bits ANDed with the mask register. A pending event whose mask bit is 0 does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Combined interrupt |
| stop_req | input | 1 | Level stop request |
| tx_allow | output | 1 | Permit to start new transmit frames |
| fifo_frame_start | input | 1 | First word of a frame entered the transmit FIFO |
| fifo_frame_end | input | 1 | Last word of the frame entered the transmit FIFO |
| tx_bd_done | input | 1 | Frame transmitted and its descriptor written back |
| tx_abort | output | 1 | Drop the partial frame (underrun, bad CRC) |
| bus_err | input | 1 | DMA bus error strobe |
| rx_bd_done | input | 1 | Frame received and its descriptor written back |
| hb_check_en | input | 1 | Heartbeat checking enabled |
| hb_seen | input | 1 | Heartbeat observed |
| rx_too_long | input | 1 | Oversized receive frame strobe |
| tx_too_long | input | 1 | Oversized transmit frame strobe |
| backoff_exp | input | 1 | Backoff timer expired strobe |
| rx_busy | input | 1 | Receive frame dropped for lack of buffer |
| tx_buf_ev | input | 1 | Transmit buffer event strobe |
| rx_buf_ev | input | 1 | Receive buffer event strobe |

## Verification
The bench drives a set strobe and a clearing write into the same bit in one cycle. A clear-wins design would lose that event. It stops with a second frame half loaded, so a design that ignores the partial frame flags completion one frame early. It also fires a bus error against a partial-only FIFO and against a FIFO with one complete frame. A design that waits for the aborted frame, or that fails to wait for the complete one, moves bit 7 by at least one edge. Heartbeat checks probe both the last and the first-past window edges, which catches an off-by-one counter. Resume is checked while bit 7 is still set, which catches a design that restarts on the request level alone.

// File: rtl/eth_ev_pkg.sv
package eth_ev_pkg;
  localparam int EV_W    = 16;
  localparam int EV_USED = 11;

  localparam int B_HB_MISS   = 10;
  localparam int B_RX_LONG   = 9;
  localparam int B_TX_LONG   = 8;
  localparam int B_STOP_DONE = 7;
  localparam int B_BACKOFF   = 6;
  localparam int B_BUS_ERR   = 5;
  localparam int B_TX_FRAME  = 4;
  localparam int B_RX_FRAME  = 3;
  localparam int B_RX_BUSY   = 2;
  localparam int B_TX_BUF    = 1;
  localparam int B_RX_BUF    = 0;

  localparam logic [EV_W-1:0] USED_MASK = (EV_W)'((1 << EV_USED) - 1);
  localparam logic [EV_W-1:0] MASK_RST  = USED_MASK & ~(EV_W'(1) << B_BACKOFF);

  typedef enum logic [1:0] {
    SQ_RUN   = 2'd0,
    SQ_DRAIN = 2'd1,
    SQ_HALT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/eth_ev_hb_watch.sv
module eth_ev_hb_watch #(
  parameter int WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic trigger,
  input  logic hb_seen,
  output logic miss
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt_q;
  logic          miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      miss_q <= 1'b0;
      if (cnt_q != '0) begin
        if (hb_seen) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(1)) begin
          cnt_q  <= '0;
          miss_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (trigger && enable) cnt_q <= CW'(WIN);
    end
  end

  assign miss = miss_q;

  // R10: a miss only follows a last window cycle without heartbeat
  assert_miss_at_window_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |-> $past(cnt_q == CW'(1) && !hb_seen));
endmodule

// File: rtl/eth_ev_stop_seq.sv
module eth_ev_stop_seq
  import eth_ev_pkg::*;
#(
  parameter int MAX_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic bus_err,
  input  logic frame_start,
  input  logic frame_end,
  input  logic frame_sent,
  input  logic done_pending,
  output logic tx_allow,
  output logic tx_abort,
  output logic done_pulse
);
  localparam int CW = $clog2(MAX_FRAMES + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] full_q, full_d;
  logic          part_q, part_d;
  logic          stopping, drained;

  always_comb begin
    part_d = part_q;
    full_d = full_q;
    if (frame_end) begin
      part_d = 1'b0;
      if (full_d != CW'(MAX_FRAMES)) full_d = full_d + CW'(1);
    end
    if (frame_start) part_d = 1'b1;
    if (frame_sent && full_q != '0) full_d = full_d - CW'(1);
    if (bus_err) part_d = 1'b0;

    stopping = (state_q == SQ_DRAIN) ||
               (state_q == SQ_RUN && (stop_req || bus_err));
    drained  = (full_d == '0) && !part_d;

    state_d = state_q;
    unique case (state_q)
      SQ_RUN:   if (stopping) state_d = drained ? SQ_HALT : SQ_DRAIN;
      SQ_DRAIN: if (drained) state_d = SQ_HALT;
      SQ_HALT:  if (!stop_req && !done_pending) state_d = SQ_RUN;
      default:  state_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      full_q  <= '0;
      part_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      full_q  <= full_d;
      part_q  <= part_d;
    end
  end

  assign done_pulse = stopping && drained;
  assign tx_allow   = (state_q == SQ_RUN) && !stop_req;
  assign tx_abort   = bus_err && part_q;

  // R7: completion is flagged only with an empty FIFO
  assert_done_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (full_q == '0 && !part_q));
  // R8: an aborted partial frame is gone after the edge
  assert_abort_drops_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> (!part_q || $past(frame_start)));
endmodule

// File: rtl/eth_ev_regs.sv
module eth_ev_regs
  import eth_ev_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [EV_W-1:0] reg_wdata,
  input  logic [EV_W-1:0] set_vec,
  output logic [EV_W-1:0] reg_rdata,
  output logic [EV_W-1:0] events,
  output logic            irq
);
  logic [EV_W-1:0] ev_q, mask_q, clr, ev_d;

  assign clr  = (reg_wr && !reg_sel) ? reg_wdata : '0;
  assign ev_d = ((ev_q & ~clr) | set_vec) & USED_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= MASK_RST;
    end else begin
      ev_q <= ev_d;
      if (reg_wr && reg_sel) mask_q <= reg_wdata & USED_MASK;
    end
  end

  assign reg_rdata = reg_sel ? mask_q : ev_q;
  assign events    = ev_q;
  assign irq       = |(ev_q & mask_q);

  for (genvar i = 0; i < EV_USED; i++) begin : g_chk
    // R4: a set strobe is never lost to a same-cycle clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> ev_q[i]);
    // R2: writing one clears the bit when nothing sets it
    assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && reg_wdata[i] && !set_vec[i]) |=> !ev_q[i]);
  end

  // R3: reserved bits read zero
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[EV_W-1:EV_USED] == '0);
endmodule

// File: rtl/eth_event_ctrl.sv
module eth_event_ctrl
  import eth_ev_pkg::*;
#(
  parameter int HB_WINDOW  = 8,
  parameter int MAX_FRAMES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  input  logic        stop_req,
  output logic        tx_allow,
  input  logic        fifo_frame_start,
  input  logic        fifo_frame_end,
  input  logic        tx_bd_done,
  output logic        tx_abort,
  input  logic        bus_err,
  input  logic        rx_bd_done,
  input  logic        hb_check_en,
  input  logic        hb_seen,
  input  logic        rx_too_long,
  input  logic        tx_too_long,
  input  logic        backoff_exp,
  input  logic        rx_busy,
  input  logic        tx_buf_ev,
  input  logic        rx_buf_ev
);
  logic [EV_W-1:0] set_vec, events;
  logic            hb_miss, stop_done;

  eth_ev_hb_watch #(.WIN(HB_WINDOW)) u_hb (
    .clk(clk), .rst_n(rst_n), .enable(hb_check_en), .trigger(tx_bd_done),
    .hb_seen(hb_seen), .miss(hb_miss)
  );

  eth_ev_stop_seq #(.MAX_FRAMES(MAX_FRAMES)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .bus_err(bus_err),
    .frame_start(fifo_frame_start), .frame_end(fifo_frame_end),
    .frame_sent(tx_bd_done), .done_pending(events[B_STOP_DONE]),
    .tx_allow(tx_allow), .tx_abort(tx_abort), .done_pulse(stop_done)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[B_HB_MISS]   = hb_miss;
    set_vec[B_RX_LONG]   = rx_too_long;
    set_vec[B_TX_LONG]   = tx_too_long;
    set_vec[B_STOP_DONE] = stop_done;
    set_vec[B_BACKOFF]   = backoff_exp;
    set_vec[B_BUS_ERR]   = bus_err;
    set_vec[B_TX_FRAME]  = tx_bd_done;
    set_vec[B_RX_FRAME]  = rx_bd_done;
    set_vec[B_RX_BUSY]   = rx_busy;
    set_vec[B_TX_BUF]    = tx_buf_ev;
    set_vec[B_RX_BUF]    = rx_buf_ev;
  end

  eth_ev_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .set_vec(set_vec), .reg_rdata(reg_rdata),
    .events(events), .irq(irq)
  );

  // R6: no start permit while a stop is requested
  assert_no_permit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !tx_allow);
  // R11: interrupt tracks pending events
  assert_irq_needs_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (events != '0));
endmodule

// File: tb/test_eth_event_ctrl.sv
module test_eth_event_ctrl;
  localparam int WIN = 8;
  localparam int P_FSTART = 0, P_FEND = 1, P_TXDONE = 2, P_BUSERR = 3,
                 P_RXDONE = 4, P_HBSEEN = 5, P_RXLONG = 6, P_TXLONG = 7,
                 P_BACKOFF = 8, P_RXBUSY = 9, P_TXBUF = 10, P_RXBUF = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq, tx_allow, tx_abort;
  logic stop_req = 1'b0, hb_check_en = 1'b0;
  logic [11:0] pin = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  eth_event_ctrl #(.HB_WINDOW(WIN), .MAX_FRAMES(4)) i_eth_event_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .stop_req(stop_req), .tx_allow(tx_allow),
    .fifo_frame_start(pin[P_FSTART]), .fifo_frame_end(pin[P_FEND]),
    .tx_bd_done(pin[P_TXDONE]), .tx_abort(tx_abort), .bus_err(pin[P_BUSERR]),
    .rx_bd_done(pin[P_RXDONE]), .hb_check_en(hb_check_en), .hb_seen(pin[P_HBSEEN]),
    .rx_too_long(pin[P_RXLONG]), .tx_too_long(pin[P_TXLONG]),
    .backoff_exp(pin[P_BACKOFF]), .rx_busy(pin[P_RXBUSY]),
    .tx_buf_ev(pin[P_TXBUF]), .rx_buf_ev(pin[P_RXBUF])
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input int idx);
    pin[idx] = 1'b1;
    tick();
    pin[idx] = 1'b0;
  endtask

  task automatic ev_is(string req, logic [15:0] exp);
    logic [15:0] v;
    rd(1'b0, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    ev_is("R1 event reg", 16'h0000);
    rd(1'b1, v); check("R1 mask reg", v, 16'h07BF);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 tx_allow", {15'd0, tx_allow}, 16'd1);
  endtask

  task automatic t_events();
    pulse(P_RXBUF);  ev_is("R5 rx buf bit0", 16'h0001);
    pulse(P_TXBUF);  ev_is("R5 tx buf bit1", 16'h0003);
    wr(1'b0, 16'h0001); ev_is("R2 clear bit0 keep bit1", 16'h0002);
    pulse(P_RXBUSY); pulse(P_RXDONE); pulse(P_RXLONG); pulse(P_TXLONG);
    ev_is("R5 bits 9 8 3 2", 16'h030E);
    wr(1'b0, 16'h0000); ev_is("R2 zero write no change", 16'h030E);
    wr(1'b0, 16'hFFFF); ev_is("R2 clear all", 16'h0000);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); check("R3 mask reserved zero", v, 16'h07FF);
    wr(1'b1, 16'h07BF);
  endtask

  task automatic t_set_wins();
    pin[P_RXDONE] = 1'b1;
    wr(1'b0, 16'h0008);
    pin[P_RXDONE] = 1'b0;
    ev_is("R4 set beats clear", 16'h0008);
    wr(1'b0, 16'h0008); ev_is("R4 later clear works", 16'h0000);
  endtask

  task automatic t_irq();
    pulse(P_BACKOFF);
    ev_is("R5 backoff bit6", 16'h0040);
    check("R11 masked event no irq", {15'd0, irq}, 16'd0);
    pulse(P_TXBUF);
    check("R11 enabled event irq", {15'd0, irq}, 16'd1);
    wr(1'b1, 16'h0000);
    check("R11 mask off irq low", {15'd0, irq}, 16'd0);
    wr(1'b1, 16'h07BF);
    wr(1'b0, 16'h07FF);
    check("R11 cleared irq low", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_stop_empty();
    stop_req = 1'b1;
    #1 check("R6 permit drops at once", {15'd0, tx_allow}, 16'd0);
    tick();
    ev_is("R6 done on first edge", 16'h0080);
    wr(1'b0, 16'h0080);
    tick();
    check("R9 held while request high", {15'd0, tx_allow}, 16'd0);
    stop_req = 1'b0;
    #1 check("R9 not same cycle", {15'd0, tx_allow}, 16'd0);
    tick();
    check("R9 resumes", {15'd0, tx_allow}, 16'd1);
  endtask

  task automatic t_stop_two_frames();
    pulse(P_FSTART); pulse(P_FEND); pulse(P_FSTART);
    stop_req = 1'b1;
    tick(); tick();
    ev_is("R7 waiting", 16'h0000);
    pulse(P_TXDONE);
    ev_is("R7 first frame not enough", 16'h0010);
    pulse(P_FEND);
    ev_is("R7 second frame loaded", 16'h0010);
    pulse(P_TXDONE);
    ev_is("R7 done after second", 16'h0090);
    stop_req = 1'b0;
    tick();
    check("R9 blocked by pending bit7", {15'd0, tx_allow}, 16'd0);
    wr(1'b0, 16'h07FF);
    check("R9 one edge after clear", {15'd0, tx_allow}, 16'd0);
    tick();
    check("R9 running again", {15'd0, tx_allow}, 16'd1);
  endtask

  task automatic t_buserr_partial();
    pulse(P_FSTART);
    pin[P_BUSERR] = 1'b1;
    #1 check("R8 abort on partial", {15'd0, tx_abort}, 16'd1);
    tick();
    pin[P_BUSERR] = 1'b0;
    ev_is("R8 done at once", 16'h00A0);
    check("R8 permit low", {15'd0, tx_allow}, 16'd0);
    wr(1'b0, 16'h07FF);
    tick();
    check("R9 resume after bus error", {15'd0, tx_allow}, 16'd1);
  endtask

  task automatic t_buserr_full();
    pulse(P_FSTART); pulse(P_FEND);
    pin[P_BUSERR] = 1'b1;
    #1 check("R8 no abort without partial", {15'd0, tx_abort}, 16'd0);
    tick();
    pin[P_BUSERR] = 1'b0;
    ev_is("R8 wait complete frame", 16'h0020);
    pulse(P_TXDONE);
    ev_is("R8 done after frame", 16'h00B0);
    wr(1'b0, 16'h07FF);
    tick();
  endtask

  task automatic t_heartbeat();
    hb_check_en = 1'b1;
    pulse(P_TXDONE);
    repeat (WIN) tick();
    ev_is("R10 not yet", 16'h0010);
    tick();
    ev_is("R10 miss flagged", 16'h0410);
    wr(1'b0, 16'h07FF);
    pulse(P_TXDONE);
    repeat (WIN - 1) tick();
    pin[P_HBSEEN] = 1'b1;
    tick();
    pin[P_HBSEEN] = 1'b0;
    repeat (3) tick();
    ev_is("R10 last edge heartbeat", 16'h0010);
    wr(1'b0, 16'h07FF);
    hb_check_en = 1'b0;
    pulse(P_TXDONE);
    repeat (WIN + 3) tick();
    ev_is("R10 disabled", 16'h0010);
    wr(1'b0, 16'h07FF);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_events();
    t_reserved();
    t_set_wins();
    t_irq();
    t_stop_empty();
    t_stop_two_frames();
    t_buserr_partial();
    t_buserr_full();
    t_heartbeat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule